// File: doc/BRIEF.md
# Edge Counter with Reload and Compare

This block counts transitions of an external, asynchronous input rather than clock cycles. A two-bit select chooses which transitions count: rising, falling, both, or none. The input passes through a two-flop synchronizer before edge detection. At most one count is added per system clock.

When a counted transition arrives while the count is at all-ones, the counter does not wrap to zero. It loads a programmable reload value and raises a sticky overflow flag. A compare value is checked against each new count, and a match raises a sticky compare flag. A compare value below the reload value lies outside the counting range and never matches.

Each flag stays set until its own clear input is pulsed. While the interrupt enable is high, either flag drives the interrupt request.

Top module: `evt_counter`

## Requirements
- R1: After reset the count is 0000h, both flags are 0 and the interrupt request is 0.
- R2: With select 01, each rising edge of the input adds one to the count and falling edges are ignored. The new count is visible three clock edges after the edge at which the input first meets the synchronizer.
- R3: With select 10, each falling edge adds one to the count and rising edges are ignored.
- R4: With select 11, every rising and every falling edge adds one to the count.
- R5: With select 00, the count holds whatever the input does.
- R6: A counted edge that arrives while the count is FFFFh loads the reload value into the counter instead of 0000h.
- R7: The overflow flag is set on the same clock edge as every reload caused by overflow.
- R8: The compare flag is set on the clock edge where a counted step makes the count equal to the compare value. This includes a step that lands on the reload value after an overflow.
- R9: If the compare value is below the reload value, the compare flag never sets, even when the count passes that value.
- R10: Each flag stays set through later counted steps until a one-cycle pulse on its own clear input, which clears it.
- R11: If a flag's set event and its clear pulse fall on the same clock edge, the flag ends up set.
- R12: The interrupt request is high exactly when the interrupt enable is high and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 1 | Asynchronous input whose edges are counted |
| edge_sel | input | 2 | 00 none, 01 rising, 10 falling, 11 both |
| reload_val | input | W (16) | Value loaded on overflow; lower bound of the counting range |
| compare_val | input | W (16) | Value compared against each new count |
| irq_en | input | 1 | Interrupt enable |
| clr_ovf | input | 1 | One-cycle pulse that clears the overflow flag |
| clr_cmp | input | 1 | One-cycle pulse that clears the compare flag |
| count_o | output | W (16) | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on a single clock edge, and the bench provokes each one.

The first is an overflow reload coinciding with a compare match. The bench sets the compare value equal to the reload value and steps the count past FFFFh. Both flags must rise together, and the compare flag must stay clear on the way up.

The second is a flag's set event coinciding with its clear pulse. The bench counts sync stages to place the clear pulse on the exact edge where the overflow reload happens. The overflow flag must read as set afterwards.

// File: rtl/evt_cnt_pkg.sv
// Package: shared encodings for the edge counter.
// Assumes: the edge select port carries these codes directly.
package evt_cnt_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/evt_cnt_edge_detect.sv
// Module: synchronizes the raw input through SYNC flops and
// produces a one-cycle step pulse for each transition that the select
// enables. Assumes the input is low (or settled) when reset is released.
module evt_cnt_edge_detect
    import evt_cnt_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] sel_i,
    output logic       step_o
);
    localparam int CHAIN = SYNC + 1;

    logic [CHAIN-1:0] chain_q;
    logic             now_lvl;
    logic             old_lvl;

    // Shift the raw input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], pin_i};
    end

    assign now_lvl = chain_q[SYNC-1];
    assign old_lvl = chain_q[SYNC];

    // Decode the selected transition type into a step pulse.
    always_comb begin
        unique case (edge_sel_e'(sel_i))
            EDGE_RISE: step_o = now_lvl & ~old_lvl;
            EDGE_FALL: step_o = ~now_lvl & old_lvl;
            EDGE_ANY:  step_o = now_lvl ^ old_lvl;
            default:   step_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_cnt_counter.sv
// Module: count register that advances on a step pulse and loads the
// reload value instead of wrapping. Exposes the value it will take on a
// step so the flag logic can compare in the same cycle.
module evt_cnt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] next_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] count_q;

    // Overflow happens only on a step taken from the top value.
    assign wrap_o  = step_i && (count_q == TOP);
    assign next_o  = (count_q == TOP) ? reload_i : count_q + 1'b1;
    assign count_o = count_q;

    // Advance or reload the count on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (step_i) count_q <= next_o;
    end
endmodule

// File: rtl/evt_cnt_flags.sv
// Module: sticky overflow and compare flags plus interrupt request.
// Assumes the clear inputs are one-cycle pulses; a set wins over a clear.
module evt_cnt_flags #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         wrap_i,
    input  logic [W-1:0] next_i,
    input  logic [W-1:0] cmp_i,
    input  logic [W-1:0] reload_i,
    input  logic         clr_ovf_i,
    input  logic         clr_cmp_i,
    input  logic         ie_i,
    output logic         ovf_o,
    output logic         cmp_o,
    output logic         irq_o
);
    logic in_range;
    logic hit;
    logic ovf_q;
    logic cmp_q;

    // A compare below the reload value is outside the counting range.
    assign in_range = (cmp_i >= reload_i);
    assign hit      = step_i && in_range && (next_i == cmp_i);

    // Overflow flag: set on wrap, else clear on pulse, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (wrap_i)    ovf_q <= 1'b1;
        else if (clr_ovf_i) ovf_q <= 1'b0;
    end

    // Compare flag: set on hit, else clear on pulse, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         cmp_q <= 1'b0;
        else if (hit)       cmp_q <= 1'b1;
        else if (clr_cmp_i) cmp_q <= 1'b0;
    end

    assign ovf_o = ovf_q;
    assign cmp_o = cmp_q;
    assign irq_o = ie_i & (ovf_q | cmp_q);
endmodule

// File: rtl/evt_counter.sv
// Module: top of the edge counter. Joins synchronizer/edge detect,
// count register and flag logic. Assumes one system clock domain.
module evt_counter #(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_in,
    input  logic [1:0]   edge_sel,
    input  logic [W-1:0] reload_val,
    input  logic [W-1:0] compare_val,
    input  logic         irq_en,
    input  logic         clr_ovf,
    input  logic         clr_cmp,
    output logic [W-1:0] count_o,
    output logic         ovf_flag,
    output logic         cmp_flag,
    output logic         irq
);
    logic         step;
    logic         wrap;
    logic [W-1:0] next_val;

    evt_cnt_edge_detect #(.SYNC(SYNC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_in),
        .sel_i  (edge_sel),
        .step_o (step)
    );

    evt_cnt_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .reload_i (reload_val),
        .count_o  (count_o),
        .next_o   (next_val),
        .wrap_o   (wrap)
    );

    evt_cnt_flags #(.W(W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .wrap_i    (wrap),
        .next_i    (next_val),
        .cmp_i     (compare_val),
        .reload_i  (reload_val),
        .clr_ovf_i (clr_ovf),
        .clr_cmp_i (clr_cmp),
        .ie_i      (irq_en),
        .ovf_o     (ovf_flag),
        .cmp_o     (cmp_flag),
        .irq_o     (irq)
    );
endmodule

// File: rtl/evt_counter_checks.sv
// Module: property checker for the edge counter, bound to every
// instance of the top. Observes ports only.
module evt_counter_checks #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   edge_sel,
    input logic [W-1:0] reload_val,
    input logic [W-1:0] compare_val,
    input logic         irq_en,
    input logic         clr_ovf,
    input logic         clr_cmp,
    input logic [W-1:0] count_o,
    input logic         ovf_flag,
    input logic         cmp_flag,
    input logic         irq
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    // R5: no select, no movement.
    assert_hold_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00) |=> $stable(count_o));

    // R6: any change is either +1 or a reload from the top value.
    assert_step_or_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |->
            ((count_o == $past(count_o) + 1'b1) ||
             ($past(count_o) == ALL1 && count_o == $past(reload_val))));

    // R7: leaving the top value implies the overflow flag is up.
    assert_ovf_on_leave_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_o) == ALL1 && count_o != ALL1) |-> ovf_flag);

    // R9: compare flag only rises when compare lies in range.
    assert_cmp_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> ($past(compare_val) >= $past(reload_val)));

    // R10: without a clear pulse a set flag stays set.
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);
    assert_cmp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !clr_cmp) |=> cmp_flag);

    // R12: a rising flag with enable high reaches the request.
    assert_irq_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && ($rose(ovf_flag) || $rose(cmp_flag))) |-> irq);
endmodule

bind evt_counter evt_counter_checks #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_sel    (edge_sel),
    .reload_val  (reload_val),
    .compare_val (compare_val),
    .irq_en      (irq_en),
    .clr_ovf     (clr_ovf),
    .clr_cmp     (clr_cmp),
    .count_o     (count_o),
    .ovf_flag    (ovf_flag),
    .cmp_flag    (cmp_flag),
    .irq         (irq)
);

// File: tb/evt_counter_test.sv
// Bench: table-driven edge selection checks, then directed tests for
// compare, range, overflow, clear collision and interrupt.
module evt_counter_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ext_in = 1'b0;
    logic [1:0]   edge_sel = 2'b00;
    logic [W-1:0] reload_val = '0;
    logic [W-1:0] compare_val = 16'h1234;
    logic         irq_en = 1'b0;
    logic         clr_ovf = 1'b0;
    logic         clr_cmp = 1'b0;
    logic [W-1:0] count_o;
    logic         ovf_flag;
    logic         cmp_flag;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;

    evt_counter #(.W(W), .SYNC(2)) uut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .edge_sel(edge_sel),
        .reload_val(reload_val), .compare_val(compare_val), .irq_en(irq_en),
        .clr_ovf(clr_ovf), .clr_cmp(clr_cmp), .count_o(count_o),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq(irq)
    );

    always #5 clk = ~clk;

    // Vector: {select[1:0], input level, expected count[15:0]}
    localparam int NV = 12;
    localparam logic [18:0] VEC [NV] = '{
        {2'b01, 1'b1, 16'd1},  // R2 rising counts
        {2'b01, 1'b0, 16'd1},  // R2 falling ignored
        {2'b01, 1'b1, 16'd2},
        {2'b01, 1'b0, 16'd2},
        {2'b10, 1'b1, 16'd2},  // R3 rising ignored
        {2'b10, 1'b0, 16'd3},  // R3 falling counts
        {2'b11, 1'b1, 16'd4},  // R4 both
        {2'b11, 1'b0, 16'd5},
        {2'b00, 1'b1, 16'd5},  // R5 hold
        {2'b00, 1'b0, 16'd5},
        {2'b11, 1'b1, 16'd6},
        {2'b11, 1'b0, 16'd7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic toggle_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ext_in = ~ext_in;
        end
        settle();
    endtask

    task automatic pulse_clr(input logic which_ovf);
        @(negedge clk);
        if (which_ovf) clr_ovf = 1'b1; else clr_cmp = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        clr_cmp = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 count", 32'(count_o), 32'h0);
        check("R1 flags", {30'b0, ovf_flag, cmp_flag}, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            edge_sel = VEC[v][18:17];
            ext_in   = VEC[v][16];
            settle();
            case (VEC[v][18:17])
                2'b01:   check("R2 rising select", 32'(count_o), 32'(VEC[v][15:0]));
                2'b10:   check("R3 falling select", 32'(count_o), 32'(VEC[v][15:0]));
                2'b11:   check("R4 both select", 32'(count_o), 32'(VEC[v][15:0]));
                default: check("R5 no select", 32'(count_o), 32'(VEC[v][15:0]));
            endcase
        end

        // R8 compare match, R12 interrupt
        irq_en = 1'b1;
        check("R12 irq low with no flag", 32'(irq), 32'h0);
        compare_val = 16'd9;
        toggle_n(1);
        check("R8 no match at 8", 32'(cmp_flag), 32'h0);
        toggle_n(1);
        check("R8 count 9", 32'(count_o), 32'd9);
        check("R8 match sets flag", 32'(cmp_flag), 32'h1);
        check("R12 irq high", 32'(irq), 32'h1);
        irq_en = 1'b0;
        #1;
        check("R12 irq masked", 32'(irq), 32'h0);
        irq_en = 1'b1;

        // R10 sticky then cleared
        toggle_n(1);
        check("R10 cmp flag sticky", 32'(cmp_flag), 32'h1);
        pulse_clr(1'b0);
        check("R10 cmp flag cleared", 32'(cmp_flag), 32'h0);
        check("R12 irq drops", 32'(irq), 32'h0);

        // R9 compare below reload passed on the way up
        reload_val  = 16'hFFF0;
        compare_val = 16'h0100;
        toggle_n(65535 - 10);
        check("R6 reached top", 32'(count_o), 32'hFFFF);
        check("R9 no match below reload", 32'(cmp_flag), 32'h0);
        check("R7 no overflow yet", 32'(ovf_flag), 32'h0);
        toggle_n(1);
        check("R6 reload on overflow", 32'(count_o), 32'hFFF0);
        check("R7 overflow flag set", 32'(ovf_flag), 32'h1);
        pulse_clr(1'b1);
        check("R10 ovf flag cleared", 32'(ovf_flag), 32'h0);

        // R11 set and clear on the same edge
        toggle_n(15);
        check("R6 top again", 32'(count_o), 32'hFFFF);
        @(negedge clk);
        ext_in = ~ext_in;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        clr_ovf = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_ovf = 1'b0;
        check("R11 set wins over clear", 32'(ovf_flag), 32'h1);
        check("R7 second reload", 32'(count_o), 32'hFFF0);
        pulse_clr(1'b1);

        // R8 with R7: compare equals reload, both flags on one edge
        compare_val = 16'hFFF0;
        toggle_n(15);
        check("R8 no match on way to top", 32'(cmp_flag), 32'h0);
        check("R7 clear before wrap", 32'(ovf_flag), 32'h0);
        toggle_n(1);
        check("R8 match on reload value", 32'(cmp_flag), 32'h1);
        check("R7 overflow with match", 32'(ovf_flag), 32'h1);
        check("R12 irq with both flags", 32'(irq), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule